// File: doc/BRIEF.md
# Flash In-Application Programming Command Sequencer

This block sits between a processor's register bus and a small on-chip flash made of two equal blocks. Software loads three operand registers: an address high byte, an address low byte and a data byte. It then writes a 7-bit operation code to a fourth register. The sequencer checks that code against the key bytes it requires. An accepted operation holds a busy flag high for a fixed number of cycles, which is set by a parameter for each kind of operation. When busy falls, the operation takes effect on the flash model or on the security and configuration state.

A 3-bit security field can only gain bits until reset. It sets a lock level for each block, and the more restrictive levels refuse program and erase operations aimed at that block. A code that is unknown, has wrong keys or is refused sets an error flag. It starts no busy period and changes nothing else. Software finds out that an operation has finished by polling busy. A read port returns the current contents of the flash model for inspection.

Top module: `iap_seq`

## Requirements
- R1: A write with `wr_sel`=0 loads the address high byte, 1 loads the address low byte and 2 loads the data byte. A write with `wr_sel`=3 launches an operation whose code is `wr_data[6:0]`; bit 7 is ignored.
- R2: Code 0Fh sets `sec_bits[0]`, 03h sets `sec_bits[1]` and 05h sets `sec_bits[2]`. Each needs data byte AAh and ignores both address bytes. Security bits are only ever set and stay set until reset.
- R3: Code 09h with data AAh and address high 5Ah sets `cfg0`. With data AAh and address high AAh it sets `cfg1`. Any other address high makes the code invalid.
- R4: Code 08h with data AAh and address high 55h sets `clk_dbl`.
- R5: Code 0Eh programs one byte. The new value is the old value AND the data byte, stored at index {addr_high[7], addr_low[4:0]}. Code 07h (multi-byte burst program) is always invalid.
- R6: Code 0Bh erases to FFh the 8-byte sector that holds the index. Code 0Dh erases the 32-byte block chosen by addr_high[7]. Code 01h erases the whole array.
- R7: Busy stays high for exactly 16 cycles for the program, security, configuration and clock-double codes. It stays high for 64 cycles for a sector erase, 128 for a block erase and 256 for a chip erase, starting with the cycle after the command write. The effect appears in the same cycle that busy falls.
- R8: An invalid operation sets `err`, does not raise busy and changes neither the flash nor the status. The next accepted launch clears `err`.
- R9: While busy is high, every register write is ignored, including writes of operands and commands.
- R10: Lock level coding is 0 open, 1 soft, 2 hard. Block 1 is hard when `sec_bits` is 3 or more, soft from 1 to 2 and open at 0. Block 0 is hard when `sec_bits` is 5 or more, soft from 1 to 4 and open at 0.
- R11: A program, sector erase or block erase aimed at a hard-locked block is refused as invalid. A chip erase is refused when either block is hard-locked.
- R12: After reset, busy, err, `sec_bits`, `cfg0`, `cfg1` and `clk_dbl` are 0 and every flash byte reads FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 addr high, 1 addr low, 2 data, 3 command |
| wr_data | input | 8 | Write data |
| rd_idx | input | 6 | Flash model read index |
| rd_data | output | 8 | Flash byte at `rd_idx` |
| busy | output | 1 | Operation in progress |
| err | output | 1 | Last launch was invalid or refused |
| sec_bits | output | 3 | Security field |
| cfg0 | output | 1 | Security configuration 0 programmed |
| cfg1 | output | 1 | Security configuration 1 programmed |
| clk_dbl | output | 1 | Clock-double enable status |
| lock_b0 | output | 2 | Lock level of block 0 |
| lock_b1 | output | 2 | Lock level of block 1 |

## Verification
The hardest state to reach from the ports is a register write that arrives during a busy period. Such a write must leave no trace, and its only effect could show up in a later operation. The stimulus writes a zero data byte and a chip-erase code in the middle of a busy period. It then launches a program without reloading the operands, so any write that got through would change the programmed byte or stretch the busy count. Hard-lock refusals need security bits that can never be cleared. They are therefore raised only after the random phase, and probes of both blocks and a chip erase follow at each lock level.

// File: rtl/iap_pkg.sv
package iap_pkg;

  typedef enum logic [3:0] {
    OP_BAD, OP_SB1, OP_SB2, OP_SB3, OP_SC0, OP_SC1, OP_CDBL,
    OP_PROG, OP_SERASE, OP_BERASE, OP_CERASE
  } iap_op_e;

  typedef enum logic [1:0] {
    LK_OPEN = 2'd0,
    LK_SOFT = 2'd1,
    LK_HARD = 2'd2
  } lock_e;

  localparam logic [6:0] CMD_SB1    = 7'h0F;
  localparam logic [6:0] CMD_SB2    = 7'h03;
  localparam logic [6:0] CMD_SB3    = 7'h05;
  localparam logic [6:0] CMD_SCX    = 7'h09;
  localparam logic [6:0] CMD_CDBL   = 7'h08;
  localparam logic [6:0] CMD_PROG   = 7'h0E;
  localparam logic [6:0] CMD_SERASE = 7'h0B;
  localparam logic [6:0] CMD_BERASE = 7'h0D;
  localparam logic [6:0] CMD_CERASE = 7'h01;

  localparam logic [7:0] KEY_DATA = 8'hAA;
  localparam logic [7:0] KEY_SC0  = 8'h5A;
  localparam logic [7:0] KEY_SC1  = 8'hAA;
  localparam logic [7:0] KEY_CDBL = 8'h55;

  // Lock level per block from the security field (R10)
  function automatic lock_e lock_of(input logic [2:0] f, input logic blk);
    logic hard;
    hard = blk ? (f >= 3'd3) : (f >= 3'd5);
    if (hard)          return LK_HARD;
    else if (f != 3'd0) return LK_SOFT;
    else               return LK_OPEN;
  endfunction

endpackage

// File: rtl/iap_rst_sync.sv
module iap_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/iap_decode.sv
module iap_decode import iap_pkg::*; #(
  parameter int unsigned BYTE_CYC = 16,
  parameter int unsigned SEC_CYC  = 64,
  parameter int unsigned BLK_CYC  = 128,
  parameter int unsigned CHIP_CYC = 256,
  localparam int unsigned CW = $clog2(CHIP_CYC + 1)
) (
  input  logic [6:0]    cmd,
  input  logic [7:0]    ah,
  input  logic [7:0]    dt,
  input  logic [2:0]    sec,
  output iap_op_e       op,
  output logic [CW-1:0] dur
);
  logic hard0, hard1, hard_t, key_ok;

  always_comb begin
    hard0  = (lock_of(sec, 1'b0) == LK_HARD);
    hard1  = (lock_of(sec, 1'b1) == LK_HARD);
    hard_t = ah[7] ? hard1 : hard0;
    key_ok = (dt == KEY_DATA);
    op     = OP_BAD;
    dur    = CW'(BYTE_CYC);
    case (cmd)
      CMD_SB1:  if (key_ok) op = OP_SB1;
      CMD_SB2:  if (key_ok) op = OP_SB2;
      CMD_SB3:  if (key_ok) op = OP_SB3;
      CMD_SCX: begin
        if (key_ok && ah == KEY_SC0)      op = OP_SC0;
        else if (key_ok && ah == KEY_SC1) op = OP_SC1;
      end
      CMD_CDBL: if (key_ok && ah == KEY_CDBL) op = OP_CDBL;
      CMD_PROG: if (!hard_t) op = OP_PROG;
      CMD_SERASE: if (!hard_t) begin
        op  = OP_SERASE;
        dur = CW'(SEC_CYC);
      end
      CMD_BERASE: if (!hard_t) begin
        op  = OP_BERASE;
        dur = CW'(BLK_CYC);
      end
      CMD_CERASE: if (!hard0 && !hard1) begin
        op  = OP_CERASE;
        dur = CW'(CHIP_CYC);
      end
      default: op = OP_BAD;
    endcase
  end
endmodule

// File: rtl/iap_array.sv
module iap_array import iap_pkg::*; #(
  parameter int unsigned BLK_BYTES = 32,
  parameter int unsigned SEC_BYTES = 8,
  localparam int unsigned NB    = 2 * BLK_BYTES,
  localparam int unsigned IDX_W = $clog2(NB),
  localparam int unsigned SW    = $clog2(SEC_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             apply,
  input  iap_op_e          op,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);
  logic [NB*8-1:0] flat;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    localparam logic [IDX_W-1:0] ME = IDX_W'(i);
    logic [7:0] q, d;

    always_comb begin
      d = q;
      case (op)
        OP_PROG:   if (idx == ME) d = q & data;
        OP_SERASE: if (idx[IDX_W-1:SW] == ME[IDX_W-1:SW]) d = 8'hFF;
        OP_BERASE: if (idx[IDX_W-1] == ME[IDX_W-1]) d = 8'hFF;
        OP_CERASE: d = 8'hFF;
        default:   d = q;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= 8'hFF;
      else if (apply) q <= d;
    end

    assign flat[i*8 +: 8] = q;
  end

  assign rd_data = flat[rd_idx*8 +: 8];
endmodule

// File: rtl/iap_seq.sv
module iap_seq import iap_pkg::*; #(
  parameter int unsigned BLK_BYTES = 32,
  parameter int unsigned SEC_BYTES = 8,
  parameter int unsigned BYTE_CYC  = 16,
  parameter int unsigned SEC_CYC   = 64,
  parameter int unsigned BLK_CYC   = 128,
  parameter int unsigned CHIP_CYC  = 256,
  localparam int unsigned IDX_W = $clog2(2 * BLK_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic             err,
  output logic [2:0]       sec_bits,
  output logic             cfg0,
  output logic             cfg1,
  output logic             clk_dbl,
  output logic [1:0]       lock_b0,
  output logic [1:0]       lock_b1
);
  localparam int unsigned LW = IDX_W - 1;
  localparam int unsigned CW = $clog2(CHIP_CYC + 1);
  localparam logic [1:0] SEL_AH = 2'd0, SEL_AL = 2'd1, SEL_DT = 2'd2, SEL_CMD = 2'd3;

  logic rst_n_s;
  iap_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s));

  logic [7:0]       ah_q, ah_d, dt_q, dt_d, pd_q, pd_d;
  logic [LW-1:0]    al_q, al_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CW-1:0]    cnt_q, cnt_d, dec_dur;
  iap_op_e          op_q, op_d, dec_op;
  logic             busy_q, busy_d, err_q, err_d;
  logic [2:0]       sec_q, sec_d;
  logic             c0_q, c0_d, c1_q, c1_d, cd_q, cd_d;
  logic             wr_ok, launch, done;

  iap_decode #(
    .BYTE_CYC(BYTE_CYC), .SEC_CYC(SEC_CYC), .BLK_CYC(BLK_CYC), .CHIP_CYC(CHIP_CYC)
  ) u_dec (
    .cmd(wr_data[6:0]), .ah(ah_q), .dt(dt_q), .sec(sec_q), .op(dec_op), .dur(dec_dur)
  );

  iap_array #(.BLK_BYTES(BLK_BYTES), .SEC_BYTES(SEC_BYTES)) u_arr (
    .clk(clk), .rst_n(rst_n_s), .apply(done), .op(op_q), .idx(idx_q), .data(pd_q),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  // next state
  always_comb begin
    wr_ok  = wr_en && !busy_q;
    launch = wr_ok && (wr_sel == SEL_CMD);
    done   = busy_q && (cnt_q == '0);
    ah_d   = (wr_ok && wr_sel == SEL_AH) ? wr_data : ah_q;
    al_d   = (wr_ok && wr_sel == SEL_AL) ? wr_data[LW-1:0] : al_q;
    dt_d   = (wr_ok && wr_sel == SEL_DT) ? wr_data : dt_q;
    op_d   = op_q;
    idx_d  = idx_q;
    pd_d   = pd_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    err_d  = err_q;
    sec_d  = sec_q;
    c0_d   = c0_q;
    c1_d   = c1_q;
    cd_d   = cd_q;
    if (launch) begin
      err_d = (dec_op == OP_BAD);
      if (dec_op != OP_BAD) begin
        busy_d = 1'b1;
        cnt_d  = dec_dur - 1'b1;
        op_d   = dec_op;
        idx_d  = {ah_q[7], al_q};
        pd_d   = dt_q;
      end
    end else if (busy_q) begin
      cnt_d = cnt_q - 1'b1;
      if (done) begin
        busy_d = 1'b0;
        case (op_q)
          OP_SB1:  sec_d[0] = 1'b1;
          OP_SB2:  sec_d[1] = 1'b1;
          OP_SB3:  sec_d[2] = 1'b1;
          OP_SC0:  c0_d = 1'b1;
          OP_SC1:  c1_d = 1'b1;
          OP_CDBL: cd_d = 1'b1;
          default: ;
        endcase
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ah_q   <= '0;
      al_q   <= '0;
      dt_q   <= '0;
      pd_q   <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
      op_q   <= OP_BAD;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      sec_q  <= '0;
      c0_q   <= 1'b0;
      c1_q   <= 1'b0;
      cd_q   <= 1'b0;
    end else begin
      ah_q   <= ah_d;
      al_q   <= al_d;
      dt_q   <= dt_d;
      pd_q   <= pd_d;
      idx_q  <= idx_d;
      cnt_q  <= cnt_d;
      op_q   <= op_d;
      busy_q <= busy_d;
      err_q  <= err_d;
      sec_q  <= sec_d;
      c0_q   <= c0_d;
      c1_q   <= c1_d;
      cd_q   <= cd_d;
    end
  end

  assign busy     = busy_q;
  assign err      = err_q;
  assign sec_bits = sec_q;
  assign cfg0     = c0_q;
  assign cfg1     = c1_q;
  assign clk_dbl  = cd_q;
  assign lock_b0  = lock_of(sec_q, 1'b0);
  assign lock_b1  = lock_of(sec_q, 1'b1);
endmodule

// File: rtl/iap_seq_chk.sv
module iap_seq_chk #(
  parameter int unsigned CHIP_CYC = 256
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       err,
  input logic [2:0] sec_bits,
  input logic       cfg0,
  input logic       cfg1,
  input logic       clk_dbl,
  input logic [1:0] lock_b0,
  input logic [1:0] lock_b1
);
  logic [$clog2(CHIP_CYC+2):0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  AST_SEC_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (($past(sec_bits) & ~sec_bits) == 3'b000)); // R2
  AST_STATE_AT_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n) !$fell(busy) |-> $stable({sec_bits, cfg0, cfg1, clk_dbl})); // R7
  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (int'(run_q) < CHIP_CYC)); // R7
  AST_ERR_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n) $rose(err) |-> !busy); // R8
  AST_NO_LAUNCH_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) $rose(err) |-> !$past(busy)); // R9
  AST_LOCK_ORDER: assert property (@(posedge clk) disable iff (!rst_n) (lock_b0 == 2'd2) |-> (lock_b1 == 2'd2)); // R10
  AST_LOCK_CODE: assert property (@(posedge clk) disable iff (!rst_n) (lock_b0 != 2'd3) && (lock_b1 != 2'd3)); // R10
endmodule

bind iap_seq iap_seq_chk #(.CHIP_CYC(CHIP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .err(err), .sec_bits(sec_bits),
  .cfg0(cfg0), .cfg1(cfg1), .clk_dbl(clk_dbl), .lock_b0(lock_b0), .lock_b1(lock_b1)
);

// File: tb/iap_seq_tb_top.sv
`timescale 1ns/1ps
module iap_seq_tb_top;
  localparam int NB = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [5:0] rd_idx = '0;
  logic [7:0] rd_data;
  logic       busy, err, cfg0, cfg1, clk_dbl;
  logic [2:0] sec_bits;
  logic [1:0] lock_b0, lock_b1;

  always #2 clk = ~clk;

  iap_seq dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .busy(busy), .err(err), .sec_bits(sec_bits),
    .cfg0(cfg0), .cfg1(cfg1), .clk_dbl(clk_dbl), .lock_b0(lock_b0), .lock_b1(lock_b1)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [7:0] m_mem [NB];
  logic [2:0] m_sec;
  logic       m_c0, m_c1, m_cd, m_err;
  logic [7:0] m_ah, m_al, m_dt;

  task automatic chk_eq(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int exp_lock(input logic [2:0] f, input bit blk);
    if (blk) return (f >= 3) ? 2 : ((f != 0) ? 1 : 0);
    return (f >= 5) ? 2 : ((f != 0) ? 1 : 0);
  endfunction

  function automatic int exp_dur(input logic [6:0] c, input logic [7:0] ah, input logic [7:0] dt,
                                 input logic [2:0] f);
    bit h1, h0, hb;
    h1 = (f >= 3);
    h0 = (f >= 5);
    hb = ah[7] ? h1 : h0;
    case (c)
      7'h0F, 7'h03, 7'h05: return (dt == 8'hAA) ? 16 : 0;
      7'h09: return (dt == 8'hAA && (ah == 8'h5A || ah == 8'hAA)) ? 16 : 0;
      7'h08: return (dt == 8'hAA && ah == 8'h55) ? 16 : 0;
      7'h0E: return hb ? 0 : 16;
      7'h0B: return hb ? 0 : 64;
      7'h0D: return hb ? 0 : 128;
      7'h01: return (h0 || h1) ? 0 : 256;
      default: return 0;
    endcase
  endfunction

  function automatic void apply_model(input logic [6:0] c);
    int idx;
    idx = {m_ah[7], m_al[4:0]};
    case (c)
      7'h0F: m_sec[0] = 1'b1;
      7'h03: m_sec[1] = 1'b1;
      7'h05: m_sec[2] = 1'b1;
      7'h09: if (m_ah == 8'h5A) m_c0 = 1'b1; else m_c1 = 1'b1;
      7'h08: m_cd = 1'b1;
      7'h0E: m_mem[idx] = m_mem[idx] & m_dt;
      7'h0B: for (int i = 0; i < NB; i++) if (i / 8 == idx / 8) m_mem[i] = 8'hFF;
      7'h0D: for (int i = 0; i < NB; i++) if (i / 32 == idx / 32) m_mem[i] = 8'hFF;
      7'h01: for (int i = 0; i < NB; i++) m_mem[i] = 8'hFF;
      default: ;
    endcase
  endfunction

  task automatic wr(input logic [1:0] s, input logic [7:0] v);
    wr_en = 1'b1; wr_sel = s; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_state(input string rq);
    chk_eq({rq, " R2 sec_bits"}, sec_bits, m_sec);
    chk_eq({rq, " R3 cfg0"}, cfg0, m_c0);
    chk_eq({rq, " R3 cfg1"}, cfg1, m_c1);
    chk_eq({rq, " R4 clk_dbl"}, clk_dbl, m_cd);
    chk_eq({rq, " R10 lock_b0"}, lock_b0, exp_lock(m_sec, 1'b0));
    chk_eq({rq, " R10 lock_b1"}, lock_b1, exp_lock(m_sec, 1'b1));
  endtask

  task automatic check_mem_all(input string rq);
    for (int i = 0; i < NB; i++) begin
      rd_idx = 6'(i);
      @(negedge clk);
      chk_eq(rq, rd_data, m_mem[i]);
    end
  endtask

  task automatic run_cmd(input logic [7:0] ah, input logic [7:0] al, input logic [7:0] dt,
                         input logic [7:0] code, input bit load, input bit poke, input string rq);
    int exp_d;
    int n;
    if (load) begin
      wr(2'd0, ah); wr(2'd1, al); wr(2'd2, dt);
      m_ah = ah; m_al = al; m_dt = dt;
    end
    exp_d = exp_dur(code[6:0], m_ah, m_dt, m_sec);
    wr(2'd3, code);
    n = 0;
    while (busy === 1'b1 && n < 1000) begin
      if (poke && n == 2) begin wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'h00; end
      else if (poke && n == 3) begin wr_en = 1'b1; wr_sel = 2'd3; wr_data = 8'h01; end
      else wr_en = 1'b0;
      n++;
      @(negedge clk);
    end
    wr_en = 1'b0;
    chk_eq({rq, " R7 busy cycles"}, n, exp_d);
    m_err = (exp_d == 0);
    if (exp_d != 0) apply_model(code[6:0]);
    chk_eq({rq, " R8 err"}, err, m_err);
    check_state(rq);
    rd_idx = {m_ah[7], m_al[4:0]};
    @(negedge clk);
    chk_eq({rq, " R5/R6 flash byte"}, rd_data, m_mem[rd_idx]);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2718);
    for (int i = 0; i < NB; i++) m_mem[i] = 8'hFF;
    m_sec = '0; m_c0 = 0; m_c1 = 0; m_cd = 0; m_err = 0;
    m_ah = '0; m_al = '0; m_dt = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12 reset state
    chk_eq("R12 busy", busy, 0);
    chk_eq("R12 err", err, 0);
    check_state("R12");
    check_mem_all("R12 flash erased");

    // R5 program, then AND into the same byte; R1 bit 7 of code ignored
    run_cmd(8'h00, 8'h03, 8'h5A, 8'h0E, 1, 0, "R5 prog");
    run_cmd(8'h00, 8'h03, 8'h0F, 8'h8E, 1, 0, "R1 R5 prog bit7");
    // R5 burst program rejected
    run_cmd(8'h00, 8'h04, 8'h00, 8'h07, 1, 0, "R5 burst");
    // R3 wrong key, then the two configs (err cleared, R8)
    run_cmd(8'h55, 8'h00, 8'hAA, 8'h09, 1, 0, "R3 bad key");
    run_cmd(8'h5A, 8'h00, 8'hAA, 8'h09, 1, 0, "R3 cfg0");
    run_cmd(8'hAA, 8'h00, 8'hAA, 8'h09, 1, 0, "R3 cfg1");
    // R4 wrong data, then valid
    run_cmd(8'h55, 8'h00, 8'h00, 8'h08, 1, 0, "R4 bad key");
    run_cmd(8'h55, 8'h00, 8'hAA, 8'h08, 1, 0, "R4 clkdbl");
    // R6 program block 1, sector erase in block 0
    run_cmd(8'h80, 8'h05, 8'h33, 8'h0E, 1, 0, "R5 prog blk1");
    run_cmd(8'h00, 8'h02, 8'h00, 8'h0B, 1, 0, "R6 sector erase");
    // R9 writes during busy ignored; second program reuses held operands
    run_cmd(8'h00, 8'h10, 8'hC3, 8'h0E, 1, 1, "R9 poke");
    run_cmd(8'h00, 8'h10, 8'hC3, 8'h0E, 0, 0, "R9 reuse operands");
    run_cmd(8'h80, 8'h00, 8'h00, 8'h0D, 1, 0, "R6 block erase");
    check_mem_all("R6 flash after block erase");

    // random mix
    for (int k = 0; k < 120; k++) begin
      int unsigned r;
      logic [7:0] code;
      logic [7:0] ah;
      r = $urandom_range(0, 19);
      ah = 8'($urandom);
      if (r < 7)       code = 8'h0E;
      else if (r < 10) code = 8'h0B;
      else if (r < 12) code = 8'h0D;
      else if (r == 12) code = 8'h01;
      else if (r < 15) code = 8'h07;
      else if (r < 17) code = 8'($urandom);
      else             code = (r == 17) ? 8'h09 : 8'h08;
      code[7] = 1'($urandom);
      run_cmd(ah, 8'($urandom), 8'($urandom), code, 1, (k % 17) == 5, "rnd R5 R6 R8");
    end
    check_mem_all("R5 R6 flash after random");

    // security progression, R2 R10 R11
    run_cmd(8'h00, 8'h00, 8'h55, 8'h0F, 1, 0, "R2 sb1 bad key");
    run_cmd(8'h12, 8'h34, 8'hAA, 8'h0F, 1, 0, "R2 sb1");
    run_cmd(8'h80, 8'h01, 8'h0F, 8'h0E, 1, 0, "R10 soft blk1 prog");
    run_cmd(8'h00, 8'h00, 8'hAA, 8'h03, 1, 0, "R2 sb2");
    run_cmd(8'h80, 8'h02, 8'h00, 8'h0E, 1, 0, "R11 hard blk1 prog");
    run_cmd(8'h80, 8'h02, 8'h00, 8'h0D, 1, 0, "R11 hard blk1 erase");
    run_cmd(8'h00, 8'h02, 8'h11, 8'h0E, 1, 0, "R11 soft blk0 prog");
    run_cmd(8'h00, 8'h00, 8'h00, 8'h01, 1, 0, "R11 chip erase refused");
    run_cmd(8'hFF, 8'hFF, 8'hAA, 8'h05, 1, 0, "R2 sb3");
    run_cmd(8'h00, 8'h02, 8'h00, 8'h0E, 1, 0, "R11 hard blk0 prog");
    run_cmd(8'h00, 8'h02, 8'h00, 8'h0B, 1, 0, "R11 hard blk0 sector");
    run_cmd(8'h5A, 8'h00, 8'hAA, 8'h09, 1, 0, "R3 cfg0 after lock");
    check_mem_all("R11 flash after locks");

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule